// File: doc/BRIEF.md
# Byte-Handshake I2C Bus Master

This block is an I2C bus master that a processor drives one byte at a time. Software loads a byte into the data register and writes the status register to begin a transfer. The block sends a START condition and then that byte. When the ninth clock (the acknowledge slot) completes, the block raises a pending flag. It then holds SCL low until software clears the flag, which starts the next step. Each step is one of three things: another byte, a repeated START, or a STOP.

The status register selects one of two directions. In master transmit, each byte comes from the data register. In master receive, each byte is shifted into the data register, and the master answers it with ACK or NACK as selected by a software bit. The usual way to read a device register uses both directions in one transfer:

1. Write the device address and the register index in transmit mode.
2. Issue a repeated START with the read address.
3. Receive the data bytes, clearing acknowledge generation before the last byte so that the slave gets a NACK.

The SCL rate is the system clock divided by a prescaler (16 or 512) and then by a 4-bit divider plus one. The bus pins are open-drain: each output asks for the line to be pulled low, and the wired-AND SDA level comes back on an input.

Top module: `i2cm_byte_master`

## Requirements
- R1: One SCL period lasts P×(D+1) system clocks. P is 16 when control bit 6 is 0 and 512 when it is 1. D is control bits 3:0.
- R2: Writing status with bit 7, bit 5 and bit 4 all set, while the bus is idle, produces a START. SDA falls while SCL is high. The data register byte is then sent MSB first. Status bit 5 reads 1 from then until the STOP completes. While idle, both lines are released.
- R3: When a byte's acknowledge slot completes, the block does three things. It sets the pending flag (control bit 4). It loads status bit 0 with the SDA level seen in that slot (1 = NACK). It holds SCL low for as long as the pending flag stays set.
- R4: Writing control bit 4 as 1 has no effect on the pending flag. Writing it as 0 clears the flag and starts the next queued action.
- R5: With status bits 7:6 = 11, each pending-flag clear sends the current data register byte, MSB first.
- R6: With status bits 7:6 = 10, each pending-flag clear receives a byte, MSB first, into the data register. In the acknowledge slot the master drives SDA low if control bit 7 is 1 and leaves it released (NACK) if it is 0.
- R7: A START command written while the pending flag is set takes effect when the flag is cleared. It produces a repeated START, with no STOP before it, followed by the data register byte.
- R8: Writing status with bit 4 set and bit 5 clear while busy queues a STOP. When the pending flag is cleared, SDA rises while SCL is high. After that, both lines are released and status bit 5 reads 0.
- R9: The irq output is high exactly when the pending flag and control bit 5 are both set.
- R10: The first byte after a START or repeated START goes out unchanged. The read/write bit in bit 0 is whatever software wrote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Byte-complete interrupt |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The bound checker watches, on every cycle, the relations between the pending flag, the status bits and the pin drivers. It confirms that SCL stays pulled low while the flag holds, that the NACK bit moves only when a byte completes, and that both lines are free whenever the engine is idle or has just finished a STOP. The bench's scenarios cover the rest, using a behavioural slave on the wired bus. They show the exact SCL period for each prescaler and divider setting, the byte values seen on the wire in each direction, the ACK or NACK the master returns under software control, and a repeated START with no STOP before it.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int DIV_W = 4;
    localparam int BYTE_W = 8;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;

    typedef struct packed {
        logic             ack_en;
        logic             slow_pre;
        logic             int_en;
        logic             pend;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_A,
        ST_START_B,
        ST_RS_A,
        ST_RS_B,
        ST_RS_C,
        ST_BIT,
        ST_HOLD,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C
    } eng_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } pull_t;

    function automatic logic [7:0] stat_word(input logic [1:0] mode, input logic busy,
                                             input logic txen, input logic nack);
        return {mode, busy, txen, 3'b000, nack};
    endfunction

    function automatic pull_t pull_of(input eng_state_t st, input logic [1:0] q,
                                      input logic [3:0] bitn, input logic is_tx,
                                      input logic msb, input logic ack_en);
        pull_t p;
        p = '{scl: 1'b0, sda: 1'b0};
        case (st)
            ST_START_A: p = '{scl: 1'b0, sda: 1'b0};
            ST_START_B: p = '{scl: 1'b0, sda: 1'b1};
            ST_RS_A:    p = '{scl: 1'b1, sda: 1'b0};
            ST_RS_B:    p = '{scl: 1'b0, sda: 1'b0};
            ST_RS_C:    p = '{scl: 1'b0, sda: 1'b1};
            ST_HOLD:    p = '{scl: 1'b1, sda: 1'b0};
            ST_STOP_A:  p = '{scl: 1'b1, sda: 1'b1};
            ST_STOP_B:  p = '{scl: 1'b0, sda: 1'b1};
            ST_STOP_C:  p = '{scl: 1'b0, sda: 1'b0};
            ST_BIT: begin
                p.scl = (q < 2'd2);
                if (bitn < 4'd8) p.sda = is_tx & ~msb;
                else             p.sda = ~is_tx & ack_en;
            end
            default:    p = '{scl: 1'b0, sda: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/i2cm_clkdiv.sv
module i2cm_clkdiv
    import i2cm_pkg::*;
#(
    parameter int PRE_FAST = 16,
    parameter int PRE_SLOW = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             slow_pre,
    input  logic [DIV_W-1:0] div,
    output logic             qtick
);
    localparam int Q_FAST = PRE_FAST / 4;
    localparam int Q_SLOW = PRE_SLOW / 4;
    localparam int CW     = $clog2(Q_SLOW * (2 ** DIV_W)) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] base;
    logic [CW-1:0] divp1;
    logic [CW-1:0] limit;

    always_comb begin
        base  = slow_pre ? CW'(Q_SLOW) : CW'(Q_FAST);
        divp1 = CW'(div) + CW'(1);
        limit = base * divp1;
    end

    assign qtick = run && (cnt == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || qtick) cnt <= '0;
        else                      cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              busy,
    input  logic              byte_done,
    input  logic              ack_seen,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              cmd_taken,
    output ctrl_t             ctrl,
    output logic              mode_rx,
    output logic              start_req,
    output logic              stop_req,
    output logic [BYTE_W-1:0] data_q,
    output logic              nack,
    output logic              irq
);
    logic [1:0] mode_q;
    logic       txen_q;
    logic       wr_ctrl;
    logic       wr_stat;
    logic       wr_data;

    assign wr_ctrl = wr && (addr == RA_CTRL);
    assign wr_stat = wr && (addr == RA_STAT);
    assign wr_data = wr && (addr == RA_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.ack_en   <= wdata[7];
                ctrl.slow_pre <= wdata[6];
                ctrl.int_en   <= wdata[5];
                ctrl.div      <= wdata[DIV_W-1:0];
            end
            if (byte_done)                  ctrl.pend <= 1'b1;
            else if (wr_ctrl && !wdata[4])  ctrl.pend <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= 2'b00;
            txen_q    <= 1'b0;
            start_req <= 1'b0;
            stop_req  <= 1'b0;
        end else begin
            if (cmd_taken) begin
                start_req <= 1'b0;
                stop_req  <= 1'b0;
            end
            if (wr_stat) begin
                mode_q <= wdata[7:6];
                txen_q <= wdata[4];
                if (wdata[7] && wdata[5] && wdata[4]) begin
                    start_req <= 1'b1;
                    stop_req  <= 1'b0;
                end else if (!wdata[5] && wdata[4] && busy) begin
                    stop_req  <= 1'b1;
                    start_req <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            nack   <= 1'b0;
        end else begin
            if (rx_valid)     data_q <= rx_byte;
            else if (wr_data) data_q <= wdata;
            if (byte_done)    nack   <= ack_seen;
        end
    end

    assign mode_rx = (mode_q == 2'b10);
    assign irq     = ctrl.pend & ctrl.int_en;

    always_comb begin
        case (addr)
            RA_CTRL: rdata = ctrl;
            RA_STAT: rdata = stat_word(mode_q, busy, txen_q, nack);
            RA_DATA: rdata = data_q;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              qtick,
    input  logic              pend,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              mode_rx,
    input  logic              ack_en,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sda_in,
    output logic              run,
    output logic              busy,
    output logic              cmd_taken,
    output logic              byte_done,
    output logic              ack_seen,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              scl_pull,
    output logic              sda_pull
);
    eng_state_t        st;
    logic [1:0]        q;
    logic [3:0]        bitn;
    logic [BYTE_W-1:0] sr;
    logic              is_tx;
    logic              ack_r;
    pull_t             pc;

    assign run       = (st != ST_IDLE) && (st != ST_HOLD);
    assign busy      = (st != ST_IDLE);
    assign cmd_taken = ((st == ST_IDLE) && start_req) ||
                       ((st == ST_HOLD) && !pend && (start_req || stop_req));
    assign byte_done = (st == ST_BIT) && qtick && (q == 2'd3) && (bitn == 4'd8);
    assign rx_valid  = byte_done && !is_tx;
    assign rx_byte   = sr;
    assign ack_seen  = ack_r;

    always_comb pc = pull_of(st, q, bitn, is_tx, sr[BYTE_W-1], ack_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            q        <= 2'd0;
            bitn     <= 4'd0;
            sr       <= '0;
            is_tx    <= 1'b1;
            ack_r    <= 1'b1;
            scl_pull <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            scl_pull <= pc.scl;
            sda_pull <= pc.sda;
            case (st)
                ST_IDLE: begin
                    if (start_req) begin
                        st    <= ST_START_A;
                        sr    <= tx_byte;
                        is_tx <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (!pend) begin
                        if (start_req) begin
                            st    <= ST_RS_A;
                            sr    <= tx_byte;
                            is_tx <= 1'b1;
                        end else if (stop_req) begin
                            st <= ST_STOP_A;
                        end else begin
                            st    <= ST_BIT;
                            sr    <= tx_byte;
                            is_tx <= !mode_rx;
                            q     <= 2'd0;
                            bitn  <= 4'd0;
                        end
                    end
                end
                ST_START_A: if (qtick) st <= ST_START_B;
                ST_RS_A:    if (qtick) st <= ST_RS_B;
                ST_RS_B:    if (qtick) st <= ST_RS_C;
                ST_START_B, ST_RS_C: begin
                    if (qtick) begin
                        st   <= ST_BIT;
                        q    <= 2'd0;
                        bitn <= 4'd0;
                    end
                end
                ST_STOP_A: if (qtick) st <= ST_STOP_B;
                ST_STOP_B: if (qtick) st <= ST_STOP_C;
                ST_STOP_C: if (qtick) st <= ST_IDLE;
                ST_BIT: begin
                    if (qtick) begin
                        q <= q + 2'd1;
                        if (q == 2'd2) begin
                            if (bitn == 4'd8) ack_r <= sda_in;
                            else if (!is_tx)  sr    <= {sr[BYTE_W-2:0], sda_in};
                        end
                        if (q == 2'd3) begin
                            if (bitn == 4'd8) begin
                                st <= ST_HOLD;
                            end else begin
                                bitn <= bitn + 4'd1;
                                if (is_tx) sr <= {sr[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/i2cm_byte_master.sv
module i2cm_byte_master
    import i2cm_pkg::*;
#(
    parameter int PRE_FAST = 16,
    parameter int PRE_SLOW = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_pull,
    output logic       sda_pull,
    input  logic       sda_in
);
    ctrl_t             ctrl;
    logic              mode_rx;
    logic              start_req;
    logic              stop_req;
    logic [BYTE_W-1:0] data_q;
    logic              nack_w;
    logic              busy_w;
    logic              run;
    logic              qtick;
    logic              cmd_taken;
    logic              byte_done;
    logic              ack_seen;
    logic              rx_valid;
    logic [BYTE_W-1:0] rx_byte;
    logic              pend_w;

    assign pend_w = ctrl.pend;

    i2cm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .busy      (busy_w),
        .byte_done (byte_done),
        .ack_seen  (ack_seen),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .cmd_taken (cmd_taken),
        .ctrl      (ctrl),
        .mode_rx   (mode_rx),
        .start_req (start_req),
        .stop_req  (stop_req),
        .data_q    (data_q),
        .nack      (nack_w),
        .irq       (irq)
    );

    i2cm_clkdiv #(
        .PRE_FAST (PRE_FAST),
        .PRE_SLOW (PRE_SLOW)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .slow_pre (ctrl.slow_pre),
        .div      (ctrl.div),
        .qtick    (qtick)
    );

    i2cm_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .qtick     (qtick),
        .pend      (ctrl.pend),
        .start_req (start_req),
        .stop_req  (stop_req),
        .mode_rx   (mode_rx),
        .ack_en    (ctrl.ack_en),
        .tx_byte   (data_q),
        .sda_in    (sda_in),
        .run       (run),
        .busy      (busy_w),
        .cmd_taken (cmd_taken),
        .byte_done (byte_done),
        .ack_seen  (ack_seen),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull)
    );

endmodule

// File: rtl/i2cm_byte_master_chk.sv
module i2cm_byte_master_chk (
    input logic clk,
    input logic rst,
    input logic pend,
    input logic nack,
    input logic busy,
    input logic scl_pull,
    input logic sda_pull
);
    // R3: SCL stays pulled low while the pending flag holds
    a_r3_scl_held: assert property (@(posedge clk) disable iff (rst)
        (pend && $past(pend)) |-> scl_pull);

    // R3: the NACK bit changes only together with a completed byte
    a_r3_nack_with_pend: assert property (@(posedge clk) disable iff (rst)
        !$stable(nack) |-> $rose(pend));

    // R4: the pending flag is raised only while a transfer is in progress
    a_r4_pend_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> busy);

    // R2: both lines are released while the engine stays idle
    a_r2_idle_free: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> (!scl_pull && !sda_pull));

    // R8: when the STOP completes, both lines are released
    a_r8_stop_release: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!scl_pull && !sda_pull));
endmodule

bind i2cm_byte_master i2cm_byte_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend_w),
    .nack     (nack_w),
    .busy     (busy_w),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull)
);

// File: tb/i2cm_byte_master_tb.sv
`timescale 1ns/1ps
module i2cm_byte_master_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       scl_pull;
    logic       sda_pull;
    logic       sda_in;

    logic       s_pull = 1'b0;
    logic       scl_line;
    logic       sda_line;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign scl_line = ~scl_pull;
    assign sda_line = ~(sda_pull | s_pull);
    assign sda_in   = sda_line;

    i2cm_byte_master u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull),
        .sda_in    (sda_in)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Behavioural slave at 7-bit address 0x50, plus bus monitor
    localparam logic [6:0] SLV = 7'h50;
    logic [7:0] rd_src[$];
    logic [7:0] wr_log[$];
    logic [7:0] addr_seen = 8'h00;
    bit   nack_data = 1'b0;
    int   starts = 0, stops = 0;
    int   cyc = 0, last_rise = 0, last_period = 0;
    logic p_scl = 1'b1, p_sda = 1'b1, p_irq = 1'b0;
    int   ph = 0, bitc = 0;
    bit   fresh = 1'b0, mack = 1'b1;
    logic [7:0] sh = 8'h00, txb = 8'hFF;

    always @(negedge clk) begin
        logic scl, sda;
        cyc++;
        scl = scl_line;
        sda = sda_line;
        if (!rst) begin
            // R3: while pending is flagged, SCL must stay low
            if (irq && p_irq) chk("R3 SCL held low while pending", scl, 0);
            if (scl && !p_scl) begin
                last_period = cyc - last_rise;
                last_rise = cyc;
            end
        end
        if (scl && p_scl && p_sda && !sda) begin
            starts++; ph = 1; bitc = 0; fresh = 1'b1; s_pull = 1'b0;
        end else if (scl && p_scl && !p_sda && sda) begin
            stops++; ph = 0; s_pull = 1'b0;
        end else if (ph != 0) begin
            if (scl && !p_scl) begin
                if (bitc < 8 && (ph == 1 || ph == 2)) begin
                    sh = {sh[6:0], sda};
                    if (bitc == 7) begin
                        if (ph == 1) addr_seen = sh;
                        else wr_log.push_back(sh);
                    end
                end
                if (bitc == 8 && ph == 3) mack = sda;
            end
            if (!scl && p_scl) begin
                if (fresh) fresh = 1'b0;
                else if (bitc == 7) begin
                    bitc = 8;
                    if (ph == 1)      s_pull = (addr_seen[7:1] == SLV);
                    else if (ph == 2) s_pull = !nack_data;
                    else              s_pull = 1'b0;
                end else if (bitc == 8) begin
                    bitc = 0;
                    s_pull = 1'b0;
                    if (ph == 1) begin
                        if (addr_seen[7:1] != SLV) ph = 4;
                        else if (addr_seen[0]) begin
                            ph = 3;
                            txb = (rd_src.size() > 0) ? rd_src.pop_front() : 8'hFF;
                            s_pull = !txb[7];
                        end else ph = 2;
                    end else if (ph == 3) begin
                        if (mack) ph = 4;
                        else begin
                            txb = (rd_src.size() > 0) ? rd_src.pop_front() : 8'hFF;
                            s_pull = !txb[7];
                        end
                    end
                end else begin
                    bitc++;
                    if (ph == 3) s_pull = !txb[7 - bitc];
                end
            end
        end
        p_scl = scl;
        p_sda = sda;
        p_irq = irq;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " irq arrives"}, irq, 1);
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] s;
        int n = 0;
        rd(2'd1, s);
        while (s[5] && n < 20000) begin
            rd(2'd1, s);
            n++;
        end
        chk({tag, " busy clears"}, s[5], 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int s0, p0;
        rd_src.push_back(8'h3C);
        rd_src.push_back(8'hC5);
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // Reset state
        rd(2'd0, v); chk("R4 reset control", v, 8'h00);
        rd(2'd1, v); chk("R2 reset status", v, 8'h00);
        chk("R9 reset irq", irq, 0);
        chk("R2 reset SCL free", scl_line, 1);
        chk("R2 reset SDA free", sda_line, 1);

        // R4: writing pending as 1 sets nothing
        wr(2'd0, 8'hB0);
        rd(2'd0, v); chk("R4 pend write-1 ignored", v, 8'hA0);
        chk("R9 no irq without pend", irq, 0);

        // Write transfer: address, data, NACKed data, STOP
        wr(2'd2, 8'hA0);
        wr(2'd1, 8'hF0);
        wait_irq("R2 address");
        chk("R2 one START", starts, 1);
        chk("R10 address byte on wire", addr_seen, 8'hA0);
        chk("R1 period P16 D0", last_period, 16);
        rd(2'd1, v); chk("R2 status busy, ACK", v, 8'hF0);
        rd(2'd0, v); chk("R3 pend flag set", v, 8'hB0);
        wr(2'd2, 8'h5A);
        wr(2'd0, 8'hA0);
        wait_irq("R5 data");
        chk("R5 data byte count", wr_log.size(), 1);
        chk("R5 data byte", wr_log[0], 8'h5A);
        rd(2'd1, v); chk("R3 ACK seen", v[0], 0);
        nack_data = 1'b1;
        wr(2'd2, 8'h77);
        wr(2'd0, 8'hA0);
        wait_irq("R3 nack");
        nack_data = 1'b0;
        rd(2'd1, v); chk("R3 NACK seen", v[0], 1);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'hA0);
        wait_idle("R8 stop");
        chk("R8 STOP on wire", stops, 1);
        chk("R8 SCL free", scl_line, 1);
        chk("R8 SDA free", sda_line, 1);

        // R1: divider and slow prescaler
        wr(2'd0, 8'hA3);
        wr(2'd2, 8'hA0);
        wr(2'd1, 8'hF0);
        wait_irq("R1 div3");
        chk("R1 period P16 D3", last_period, 64);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'hA3);
        wait_idle("R1 div3");
        wr(2'd0, 8'hE0);
        wr(2'd2, 8'hA0);
        wr(2'd1, 8'hF0);
        wait_irq("R1 slow");
        chk("R1 period P512 D0", last_period, 512);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'hE0);
        wait_idle("R1 slow");
        wr(2'd0, 8'hA0);

        // Address not acknowledged
        wr(2'd2, 8'hC2);
        wr(2'd1, 8'hF0);
        wait_irq("R3 addr nack");
        chk("R10 foreign address on wire", addr_seen, 8'hC2);
        rd(2'd1, v); chk("R3 address NACK", v[0], 1);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'hA0);
        wait_idle("R3 addr nack");

        // Register read: index write, repeated START, two received bytes
        wr(2'd2, 8'hA0);
        wr(2'd1, 8'hF0);
        wait_irq("R7 addr");
        wr(2'd2, 8'h12);
        wr(2'd0, 8'hA0);
        wait_irq("R7 index");
        chk("R5 index byte", wr_log[wr_log.size()-1], 8'h12);
        s0 = starts; p0 = stops;
        wr(2'd2, 8'hA1);
        wr(2'd1, 8'hB0);
        rd(2'd0, v); chk("R7 START waits for pend clear", starts, s0);
        wr(2'd0, 8'hA0);
        wait_irq("R7 read addr");
        chk("R7 repeated START seen", starts, s0 + 1);
        chk("R7 no STOP before it", stops, p0);
        chk("R10 read address byte", addr_seen, 8'hA1);
        rd(2'd1, v); chk("R7 read addr ACK", v[0], 0);
        wr(2'd0, 8'hA0);
        wait_irq("R6 byte0");
        rd(2'd2, v); chk("R6 first byte", v, 8'h3C);
        rd(2'd1, v); chk("R6 master ACK", v[0], 0);
        wr(2'd0, 8'h20);
        wait_irq("R6 byte1");
        rd(2'd2, v); chk("R6 last byte", v, 8'hC5);
        rd(2'd1, v); chk("R6 master NACK", v[0], 1);
        wr(2'd1, 8'h90);
        wr(2'd0, 8'h20);
        wait_idle("R8 read stop");
        chk("R8 STOP after read", stops, p0 + 1);

        // R9: irq gated by enable; pend kept when written as 1
        wr(2'd0, 8'h80);
        wr(2'd2, 8'hA0);
        wr(2'd1, 8'hF0);
        begin
            int n = 0;
            rd(2'd0, v);
            while (!v[4] && n < 20000) begin
                rd(2'd0, v);
                n++;
            end
        end
        chk("R9 irq low with enable off", irq, 0);
        repeat (10) @(negedge clk);
        chk("R3 SCL low during hold", scl_line, 0);
        rd(2'd0, v); chk("R3 pend set, irq off", v, 8'h90);
        wr(2'd0, 8'hB0);
        chk("R9 irq follows enable", irq, 1);
        rd(2'd0, v); chk("R4 pend kept by write-1", v, 8'hB0);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'hA0);
        wait_idle("R9 stop");
        chk("R9 irq low after clear", irq, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule